// File: doc/BRIEF.md
# Fetch Address Control-Flow Checker

This block watches the instruction fetch addresses that a processor core issues, together with the instruction word that returns for each fetch. It reads just enough of each instruction to tell a branch from a sequential instruction, and it works out the branch target. From this it predicts which addresses the next fetch may legally use. A fetch to any other address is reported as a control-flow fault.

The checker is a passive tap on the fetch path. It cannot stall the core, so the fetch side has a valid strobe and no ready: every cycle in which `fetch_valid` is high carries one observed fetch. Software or wrapper logic lowers `chk_en` while substitute instruction sequences or interrupt entry are in progress. When checking resumes, the first fetch sets a new reference point. A fault raises a sticky flag and a one-cycle interrupt pulse. It also freezes the predicted and observed addresses of the first fault so they can be inspected later.

Instructions are 32 bits wide and four bytes long. The top three bits form the class field, and the low sixteen bits hold a signed word offset.

Top module: `fcf_checker`

## Requirements
- R1: After reset, `err_flag`, `irq_req`, `exp_seq`, `exp_alt` and `obs_addr` are all zero.
- R2: The first fetch accepted after reset is not checked and raises no fault, whatever its address. It becomes the reference for the next fetch.
- R3: An instruction whose bits 31:29 are not 3'b100 is sequential. After a sequential instruction at address A, the only legal next fetch is A+4. Any other address is a fault.
- R4: An instruction whose bits 31:29 equal 3'b100 is a branch. After a branch at A, both A+4 and A+4+(sign-extended bits 15:0 shifted left by 2) are legal next fetches.
- R5: A fault sets `err_flag` on the clock edge that samples the faulty fetch. `irq_req` is high for exactly that one cycle, and only when the fault is the first one, meaning `err_flag` was low or `err_clear` was high in the same cycle.
- R6: `err_flag` stays high until `err_clear` is sampled high. If `err_clear` and a fault arrive in the same cycle, the flag stays set.
- R7: At a first fault, `exp_seq` captures A+4 and `exp_alt` captures the branch target (or A+4 if the reference was sequential). `obs_addr` captures the faulty address. These values are held unchanged while the flag stays set, including through later faults.
- R8: After a fault, the faulty fetch becomes the new reference, so checking continues from the observed address.
- R9: While `chk_en` is low, fetches raise no fault and the reference is dropped. The first fetch after `chk_en` returns high is accepted unchecked and becomes the new reference.
- R10: Cycles with `fetch_valid` low are ignored: the reference is kept and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Checking enable; low suspends checking and drops the reference |
| fetch_valid | input | 1 | One observed fetch this cycle |
| fetch_addr | input | AW (32) | Byte address of the fetch |
| fetch_instr | input | 32 | Instruction word returned for the fetch |
| err_clear | input | 1 | Clears the sticky fault flag |
| err_flag | output | 1 | Sticky control-flow fault flag |
| irq_req | output | 1 | One-cycle interrupt request on a first fault |
| exp_seq | output | AW (32) | Captured sequential successor at the first fault |
| exp_alt | output | AW (32) | Captured alternate successor (branch target) at the first fault |
| obs_addr | output | AW (32) | Captured faulty fetch address |

## Verification
A wrong reference, such as a stale address, a mis-decoded class or a bad target, shows at the ports on the next accepted fetch. That fetch either raises a false `err_flag` or fails to raise one, one clock after it is sampled. The captured addresses expose the predicted successors directly at that point. A fault in the sticky or capture logic shows as `irq_req` firing on a later fault, or as the captured values drifting while the flag is held. The bench provokes both cases. Suspended checking and idle cycles are checked by sending fetches that would be faults if they were checked, then checking the next legal fetch against the kept or new reference.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  typedef enum logic {
    CLS_SEQ    = 1'b0,
    CLS_BRANCH = 1'b1
  } fcf_class_e;
endpackage

// File: rtl/fcf_decode.sv
module fcf_decode
  import fcf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IW       = 32,
  parameter int ISZ      = 4,
  parameter int CLS_W    = 3,
  parameter logic [CLS_W-1:0] BR_CODE = 3'b100,
  parameter int IMM_W    = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [IW-1:0] instr,
  output fcf_class_e    cls,
  output logic [AW-1:0] seq_next,
  output logic [AW-1:0] br_next
);
  localparam int SHIFT = $clog2(ISZ);
  localparam int EXT_W = AW - IMM_W - SHIFT;

  logic [IMM_W-1:0] imm;
  logic [AW-1:0]    disp;

  assign imm  = instr[IMM_W-1:0];
  assign disp = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};

  always_comb begin
    cls      = (instr[IW-1 -: CLS_W] == BR_CODE) ? CLS_BRANCH : CLS_SEQ;
    seq_next = addr + AW'(ISZ);
    br_next  = seq_next + disp;
  end
endmodule

// File: rtl/fcf_predict.sv
module fcf_predict
  import fcf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          drop,
  input  fcf_class_e    cls,
  input  logic [AW-1:0] seq_next,
  input  logic [AW-1:0] br_next,
  output logic          have_ref,
  output logic [AW-1:0] pred_seq,
  output logic [AW-1:0] pred_alt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      pred_seq <= '0;
      pred_alt <= '0;
    end else if (drop) begin
      have_ref <= 1'b0;
    end else if (take) begin
      have_ref <= 1'b1;
      pred_seq <= seq_next;
      pred_alt <= (cls == CLS_BRANCH) ? br_next : seq_next;
    end
  end

  // R9
  ref_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !have_ref);
endmodule

// File: rtl/fcf_err_latch.sv
module fcf_err_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic          clear,
  input  logic [AW-1:0] pred_seq,
  input  logic [AW-1:0] pred_alt,
  input  logic [AW-1:0] obs,
  output logic          err_flag,
  output logic          irq_req,
  output logic [AW-1:0] cap_seq,
  output logic [AW-1:0] cap_alt,
  output logic [AW-1:0] cap_obs
);
  logic first;
  assign first = fault && (!err_flag || clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      irq_req  <= 1'b0;
      cap_seq  <= '0;
      cap_alt  <= '0;
      cap_obs  <= '0;
    end else begin
      err_flag <= fault || (err_flag && !clear);
      irq_req  <= first;
      if (first) begin
        cap_seq <= pred_seq;
        cap_alt <= pred_alt;
        cap_obs <= obs;
      end
    end
  end

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clear) |=> err_flag);
  // R5
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> err_flag);
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !clear) |=> !irq_req);
  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clear) |=> ($stable(cap_obs) && $stable(cap_seq) && $stable(cap_alt)));
endmodule

// File: rtl/fcf_checker.sv
module fcf_checker
  import fcf_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [IW-1:0] fetch_instr,
  input  logic          err_clear,
  output logic          err_flag,
  output logic          irq_req,
  output logic [AW-1:0] exp_seq,
  output logic [AW-1:0] exp_alt,
  output logic [AW-1:0] obs_addr
);
  fcf_class_e    cls;
  logic [AW-1:0] seq_next, br_next, pred_seq, pred_alt;
  logic          have_ref, take, fault;

  assign take  = fetch_valid && chk_en;
  assign fault = take && have_ref && (fetch_addr != pred_seq) && (fetch_addr != pred_alt);

  fcf_decode #(.AW(AW), .IW(IW)) dec_i (
    .addr(fetch_addr), .instr(fetch_instr),
    .cls(cls), .seq_next(seq_next), .br_next(br_next)
  );

  fcf_predict #(.AW(AW)) pred_i (
    .clk(clk), .rst_n(rst_n), .take(take), .drop(!chk_en),
    .cls(cls), .seq_next(seq_next), .br_next(br_next),
    .have_ref(have_ref), .pred_seq(pred_seq), .pred_alt(pred_alt)
  );

  fcf_err_latch #(.AW(AW)) err_i (
    .clk(clk), .rst_n(rst_n), .fault(fault), .clear(err_clear),
    .pred_seq(pred_seq), .pred_alt(pred_alt), .obs(fetch_addr),
    .err_flag(err_flag), .irq_req(irq_req),
    .cap_seq(exp_seq), .cap_alt(exp_alt), .cap_obs(obs_addr)
  );

  // R5
  fault_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> err_flag);
  // R9
  no_fault_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !err_flag) |=> !irq_req);
endmodule

// File: tb/fcf_checker_tb_top.sv
`timescale 1ns/1ps
module fcf_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_en = 1'b0, fetch_valid = 1'b0, err_clear = 1'b0;
  logic [31:0] fetch_addr = '0, fetch_instr = '0;
  logic        err_flag, irq_req;
  logic [31:0] exp_seq, exp_alt, obs_addr;

  always #2.5 clk = ~clk;

  fcf_checker dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_instr(fetch_instr), .err_clear(err_clear),
    .err_flag(err_flag), .irq_req(irq_req), .exp_seq(exp_seq),
    .exp_alt(exp_alt), .obs_addr(obs_addr)
  );

  typedef struct {
    logic        err;
    logic        irq;
    logic [31:0] es, ea, ob;
    int          rq;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state, built from the requirements
  bit          m_have = 0, m_flag = 0;
  logic [31:0] m_seq = 0, m_alt = 0, m_cs = 0, m_ca = 0, m_co = 0;

  function automatic logic [31:0] seq_i(input logic [31:0] imm);
    return {3'b001, 13'd0, imm[15:0]};
  endfunction
  function automatic logic [31:0] br_i(input logic [15:0] imm);
    return {3'b100, 13'd0, imm};
  endfunction

  task automatic step(input bit v, input bit en, input logic [31:0] a,
                      input logic [31:0] ins, input bit clr, input int rq);
    exp_t e;
    bit flt, first;
    @(negedge clk);
    fetch_valid = v; chk_en = en; fetch_addr = a; fetch_instr = ins; err_clear = clr;
    flt   = v && en && m_have && (a != m_seq) && (a != m_alt);
    first = flt && (!m_flag || clr);
    if (first) begin m_cs = m_seq; m_ca = m_alt; m_co = a; end
    m_flag = flt || (m_flag && !clr);
    if (!en) m_have = 0;
    else if (v) begin
      m_have = 1;
      m_seq  = a + 32'd4;
      m_alt  = (ins[31:29] == 3'b100) ? (a + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00}) : a + 32'd4;
    end
    e.err = m_flag; e.irq = first; e.es = m_cs; e.ea = m_ca; e.ob = m_co; e.rq = rq;
    q.push_back(e);
  endtask

  // monitor: compare one expected item after each clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (err_flag !== e.err || irq_req !== e.irq || exp_seq !== e.es ||
          exp_alt !== e.ea || obs_addr !== e.ob) begin
        n_bad++;
        $display("FAIL R%0d: got err=%0b irq=%0b seq=%h alt=%h obs=%h, exp err=%0b irq=%0b seq=%h alt=%h obs=%h",
                 e.rq, err_flag, irq_req, exp_seq, exp_alt, obs_addr,
                 e.err, e.irq, e.es, e.ea, e.ob);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 32'h0,   32'h0,          0, 1);  // R1 reset state
    step(1, 1, 32'h100, seq_i(32'h0),   0, 2);  // R2 first fetch unchecked
    step(1, 1, 32'h104, seq_i(32'h5),   0, 3);  // R3 sequential ok
    step(1, 1, 32'h108, br_i(16'h0003), 0, 4);  // R4 branch, target 0x118
    step(1, 1, 32'h118, br_i(16'hFFFE), 0, 4);  // R4 taken; next target 0x114
    step(1, 1, 32'h11C, seq_i(32'h0),   0, 4);  // R4 not taken
    step(0, 1, 32'hDEAD0, seq_i(32'h0), 0, 10); // R10 idle cycle ignored
    step(1, 1, 32'h120, seq_i(32'h0),   0, 10); // R10 reference kept
    step(1, 1, 32'h200, seq_i(32'h0),   0, 5);  // R5 R7 fault, capture
    step(0, 1, 32'h0,   32'h0,          0, 5);  // R5 irq gone, R6 flag held
    step(1, 1, 32'h204, seq_i(32'h0),   0, 8);  // R8 resync to faulty address
    step(1, 1, 32'h300, seq_i(32'h0),   0, 7);  // R7 later fault, no recapture
    step(0, 1, 32'h0,   32'h0,          1, 6);  // R6 clear
    step(1, 1, 32'h304, br_i(16'h0010), 0, 8);  // R8 ref 0x300 -> 0x304 ok
    step(1, 1, 32'h400, seq_i(32'h0),   0, 7);  // R7 fault after branch ref
    step(1, 1, 32'h500, seq_i(32'h0),   1, 6);  // R6 clear with fault: stays set
    step(0, 1, 32'h0,   32'h0,          1, 6);  // R6 clear
    step(1, 0, 32'h900, seq_i(32'h0),   0, 9);  // R9 disabled, no fault
    step(1, 1, 32'h50,  seq_i(32'h0),   0, 9);  // R9 new reference
    step(1, 1, 32'h54,  br_i(16'h8000), 0, 3);  // R3 ok; R4 negative target
    step(1, 1, 32'hFFFE0058, seq_i(32'h0), 0, 4); // R4 far negative taken
    step(1, 1, 32'h60,  seq_i(32'h0),   0, 3);  // R3 fault
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule